// File: doc/BRIEF.md
# Instruction Boundary Status and Trace Sequencer

At every point where an instruction finishes, this block decides whether the next instruction can start at once, whether a trace or an interrupt will be serviced first, or whether the instruction's exception hands control elsewhere. It reports that decision to the outside on a single status line, using the length of a high pulse: one cycle, two cycles or three cycles. The line is also held high without end once the core has stopped after a double fault. A separate one-cycle output tells the exception logic to take a trace.

The trace-control bits come with each completion and select one of four modes. The block remembers a trace that cannot be taken yet. This happens when the instruction aborts on a bus or address error, and when an exception raised by the instruction itself must run first. The remembered trace is issued at the next normal completion. Pulse requests that arrive while a pulse is still being driven wait in a small in-order queue. Consecutive pulses are always separated by at least one low cycle, so an observer can measure each length.

Top module: `boundary_status_seq`

## Requirements
- R1: A completion (`insn_done_i`=1, `forced_exc_i`=0) with no trace taken and `irq_pending_i`=0 drives `status_o` high for exactly 1 cycle, starting the cycle after the completion is sampled when the line is idle.
- R2: A completion where a trace is taken or `irq_pending_i`=1 drives `status_o` high for exactly 2 cycles. When both apply, `trace_req_o` is still raised, so the trace is serviced ahead of the interrupt.
- R3: `mmu_miss_i` or `exc_start_i` drives a 3-cycle pulse. If either coincides with a completion, only the 3-cycle pulse is produced for that cycle, but the completion's trace decision still applies.
- R4: Once `halt_i` is sampled high, `status_o` is high from the next cycle onward until reset, whatever the other inputs do.
- R5: `trace_mode_i` encodes 2'b00 no trace, 2'b01 trace only when `flow_change_i`=1, 2'b10 trace every instruction, and 2'b11 no trace. A trace decision raises `trace_req_o` for one cycle, the cycle after the completion.
- R6: An aborted instruction (`insn_fault_i`=1, `insn_done_i`=0) makes no pulse and no trace request. A trace its mode calls for is kept and issued at the next completion, whatever that completion's own mode is.
- R7: A completion with `forced_exc_i`=1 makes no pulse and no trace request. A wanted trace is kept and issued, with a 2-cycle pulse, at the next completion without a forced exception.
- R8: A completion with `insn_illegal_i`=1 never requests its own trace, whatever the mode.
- R9: Pulse requests that arrive while a pulse is active are held in order, up to QDEPTH entries; requests that find the queue full are dropped. Any two pulses are separated by at least one low cycle.
- R10: During and right after reset, `status_o` and `trace_req_o` are low, the queue is empty and no trace is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trace_mode_i | input | 2 | Trace-control bits latched when the instruction began |
| flow_change_i | input | 1 | Instruction altered program flow |
| insn_done_i | input | 1 | Instruction completed this cycle |
| insn_fault_i | input | 1 | Instruction aborted by bus or address error |
| insn_illegal_i | input | 1 | Instruction was illegal or unimplemented |
| forced_exc_i | input | 1 | Instruction raised its own exception |
| irq_pending_i | input | 1 | An interrupt is pending at this boundary |
| mmu_miss_i | input | 1 | Translation cache miss, table search starting |
| exc_start_i | input | 1 | Reset, bus/address error or vectored exception processing starting |
| halt_i | input | 1 | Double fault halt |
| status_o | output | 1 | Boundary status line (pulse length encodes the event) |
| trace_req_o | output | 1 | One-cycle request to take a trace |

## Verification
Every input is registered once on the way out. A pulse requested at edge k therefore raises `status_o` in the cycle after edge k, and `trace_req_o` also appears in that cycle. A queued pulse starts at the first edge after the previous pulse has ended and one low cycle has passed. The bench holds a cycle-level model of the queue and the kept trace, advances it on the same edge the design samples, and compares both outputs at every falling edge. This catches a pulse that is one cycle too long or too short, as well as a mistimed pulse.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    typedef enum logic [1:0] {
        TRC_OFF  = 2'b00,
        TRC_FLOW = 2'b01,
        TRC_ALL  = 2'b10,
        TRC_RSVD = 2'b11
    } trc_mode_e;

    typedef enum logic [1:0] {
        PL_NONE  = 2'd0,
        PL_ONE   = 2'd1,
        PL_TWO   = 2'd2,
        PL_THREE = 2'd3
    } plen_e;

    typedef struct packed {
        logic  valid;
        plen_e len;
    } pulse_req_t;

    typedef struct packed {
        logic      done;
        logic      fault;
        logic      illegal;
        logic      flow;
        logic      forced;
        logic      irq;
        trc_mode_e mode;
    } bnd_info_t;

    // Whether the instruction's own trace bits call for a trace.
    function automatic logic trace_wanted(input bnd_info_t b);
        logic w;
        case (b.mode)
            TRC_FLOW: w = b.flow;
            TRC_ALL:  w = 1'b1;
            default:  w = 1'b0;
        endcase
        return w && !b.illegal;
    endfunction

    // Higher-priority request wins when both are valid.
    function automatic pulse_req_t pick_req(input pulse_req_t hi, input pulse_req_t lo);
        return hi.valid ? hi : lo;
    endfunction

endpackage

// File: rtl/bsq_trace_decider.sv
module bsq_trace_decider
    import bsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bnd_info_t  bnd,
    output pulse_req_t req,
    output logic       trace_req_o
);

    logic carry_q;
    logic wanted;
    logic normal_done;
    logic fire;

    always_comb begin
        wanted      = trace_wanted(bnd);
        normal_done = bnd.done && !bnd.forced;
        fire        = normal_done && (carry_q || wanted);
        req.valid   = normal_done;
        req.len     = (fire || bnd.irq) ? PL_TWO : PL_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q     <= 1'b0;
            trace_req_o <= 1'b0;
        end else begin
            trace_req_o <= fire;
            if (normal_done)
                carry_q <= 1'b0;
            else if ((bnd.done && bnd.forced) || bnd.fault)
                carry_q <= carry_q || wanted;
        end
    end

    // R7
    forced_no_trace_chk: assert property (@(posedge clk) disable iff (rst)
        (bnd.done && bnd.forced) |=> !trace_req_o);

    // R5
    trace_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        trace_req_o |-> $past(bnd.done));

    // R5
    rsvd_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (bnd.done && bnd.mode == TRC_RSVD && !carry_q) |=> !trace_req_o);

    // R8
    illegal_no_trace_chk: assert property (@(posedge clk) disable iff (rst)
        (bnd.done && bnd.illegal && !carry_q) |=> !trace_req_o);

endmodule

// File: rtl/bsq_pulse_fifo.sv
module bsq_pulse_fifo
    import bsq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  plen_e din,
    input  logic  pop,
    output plen_e dout,
    output logic  empty,
    output logic  full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    plen_e          mem [DEPTH];
    logic [AW-1:0]  rd_q, wr_q;
    logic [CW-1:0]  cnt_q;
    logic           push_ok;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign push_ok = push && (!full || pop);
    assign dout    = mem[rd_q];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wr_q <= nxt(wr_q);
            if (pop)     rd_q <= nxt(rd_q);
            case ({push_ok, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R9
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R9
    fifo_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push_ok && cnt_q == CW'(1)) |=> empty);

endmodule

// File: rtl/bsq_status_shaper.sv
module bsq_status_shaper
    import bsq_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  pulse_req_t ev,
    input  logic       halt_i,
    output logic       status_o
);

    logic       busy_q;
    logic [1:0] cnt_q;
    logic       halted_q;
    logic       q_empty, q_full;
    plen_e      q_head;
    logic       push, pop, start;
    plen_e      start_len;
    logic [2:0] run_q;

    assign push      = ev.valid && (busy_q || !q_empty);
    assign pop       = !busy_q && !q_empty;
    assign start     = !busy_q && (!q_empty || ev.valid);
    assign start_len = q_empty ? ev.len : q_head;

    bsq_pulse_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (ev.len),
        .pop   (pop),
        .dout  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            cnt_q    <= '0;
            halted_q <= 1'b0;
        end else begin
            halted_q <= halted_q || halt_i;
            if (busy_q) begin
                if (cnt_q == '0) busy_q <= 1'b0;
                else             cnt_q  <= cnt_q - 1'b1;
            end else if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= 2'(start_len) - 2'd1;
            end
        end
    end

    assign status_o = busy_q || halted_q;

    always_ff @(posedge clk) begin
        if (rst)                     run_q <= '0;
        else if (!busy_q)            run_q <= '0;
        else if (run_q != 3'd7)      run_q <= run_q + 1'b1;
    end

    // R3
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (run_q < 3'd3));

    // R9
    pulse_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q == '0) |=> !busy_q);

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halt_i |=> status_o);

    // R4
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted_q |=> halted_q);

    // R9
    full_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (q_full && busy_q) |=> !q_empty);

endmodule

// File: rtl/boundary_status_seq.sv
module boundary_status_seq
    import bsq_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] trace_mode_i,
    input  logic       flow_change_i,
    input  logic       insn_done_i,
    input  logic       insn_fault_i,
    input  logic       insn_illegal_i,
    input  logic       forced_exc_i,
    input  logic       irq_pending_i,
    input  logic       mmu_miss_i,
    input  logic       exc_start_i,
    input  logic       halt_i,
    output logic       status_o,
    output logic       trace_req_o
);

    bnd_info_t  bnd;
    pulse_req_t bnd_req;
    pulse_req_t long_req;
    pulse_req_t ev;

    always_comb begin
        bnd.done     = insn_done_i;
        bnd.fault    = insn_fault_i;
        bnd.illegal  = insn_illegal_i;
        bnd.flow     = flow_change_i;
        bnd.forced   = forced_exc_i;
        bnd.irq      = irq_pending_i;
        bnd.mode     = trc_mode_e'(trace_mode_i);
        long_req.valid = mmu_miss_i || exc_start_i;
        long_req.len   = PL_THREE;
        ev = pick_req(long_req, bnd_req);
    end

    bsq_trace_decider u_decider (
        .clk         (clk),
        .rst         (rst),
        .bnd         (bnd),
        .req         (bnd_req),
        .trace_req_o (trace_req_o)
    );

    bsq_status_shaper #(.QDEPTH(QDEPTH)) u_shaper (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .halt_i   (halt_i),
        .status_o (status_o)
    );

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!trace_req_o && !status_o));

endmodule

// File: tb/boundary_status_seq_bench.sv
`timescale 1ns/1ps
module boundary_status_seq_bench;

    localparam int QD = 4;

    logic clk = 1'b0;
    logic rst;
    logic [1:0] tmode;
    logic flow, done, fault, illegal, forced, irq, mmu, exc, halt;
    logic status, treq;

    int checks = 0;
    int failures = 0;

    // reference model state
    bit m_busy, m_halt, m_carry, m_trace;
    int m_cnt;
    int mq[$];

    always #2 clk = ~clk;

    boundary_status_seq #(.QDEPTH(QD)) u_boundary_status_seq (
        .clk(clk), .rst(rst), .trace_mode_i(tmode), .flow_change_i(flow),
        .insn_done_i(done), .insn_fault_i(fault), .insn_illegal_i(illegal),
        .forced_exc_i(forced), .irq_pending_i(irq), .mmu_miss_i(mmu),
        .exc_start_i(exc), .halt_i(halt), .status_o(status), .trace_req_o(treq)
    );

    task automatic clear_in();
        tmode = 2'b00; flow = 0; done = 0; fault = 0; illegal = 0;
        forced = 0; irq = 0; mmu = 0; exc = 0; halt = 0;
    endtask

    function automatic bit wants(logic [1:0] md, logic fl, logic il);
        bit w;
        w = (md == 2'b10) || (md == 2'b01 && fl);
        return w && !il;
    endfunction

    // Advance the model by one edge using the current inputs.
    task automatic model_edge();
        bit w, ev_v;
        int ev_len;
        w = wants(tmode, flow, illegal);
        m_trace = 0;
        ev_v = 0; ev_len = 0;
        if (done && !forced) begin
            m_trace = m_carry || w;
            m_carry = 0;
            ev_v = 1; ev_len = (m_trace || irq) ? 2 : 1;
        end else if ((done && forced) || fault) begin
            m_carry = m_carry || w;
        end
        if (mmu || exc) begin ev_v = 1; ev_len = 3; end
        if (m_busy) begin
            if (m_cnt == 0) m_busy = 0; else m_cnt--;
            if (ev_v && mq.size() < QD) mq.push_back(ev_len);
        end else if (mq.size() != 0) begin
            m_busy = 1; m_cnt = mq.pop_front() - 1;
            if (ev_v) mq.push_back(ev_len);
        end else if (ev_v) begin
            m_busy = 1; m_cnt = ev_len - 1;
        end
        if (halt) m_halt = 1;
    endtask

    task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s {status,trace_req} actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(string tag);
        model_edge();
        @(posedge clk);
        @(negedge clk);
        chk(tag, {status, treq}, {m_busy || m_halt, m_trace});
        clear_in();
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic do_reset();
        rst = 1; clear_in();
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        m_busy = 0; m_halt = 0; m_carry = 0; m_trace = 0; m_cnt = 0; mq.delete();
        chk("R10", {status, treq}, 2'b00);
        rst = 0;
    endtask

    initial begin
        #700000;
        failures++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int hi;
        void'($urandom(32'h5eed_0042));
        clear_in();
        do_reset();
        idle(2, "R10");

        // R1: plain boundary, one-cycle pulse
        done = 1; step("R1");
        if (status !== 1'b1) begin failures++; $display("FAIL R1 status actual=%b expected=1", status); end
        checks++;
        idle(3, "R1");

        // R5 modes
        done = 1; tmode = 2'b01; flow = 0; step("R5"); idle(3, "R5");
        done = 1; tmode = 2'b01; flow = 1; step("R5"); idle(3, "R5");
        done = 1; tmode = 2'b11; flow = 1; step("R5"); idle(3, "R5");

        // R2: trace every instruction, then interrupt only, then both
        done = 1; tmode = 2'b10; step("R2");
        hi = 1;
        for (int i = 0; i < 4; i++) begin step("R2"); if (status) hi++; end
        checks++;
        if (hi != 2) begin failures++; $display("FAIL R2 pulse length actual=%0d expected=2", hi); end
        done = 1; irq = 1; step("R2"); idle(3, "R2");
        done = 1; irq = 1; tmode = 2'b10; step("R2"); idle(3, "R2");

        // R6: fault defers trace to next completion
        fault = 1; tmode = 2'b10; step("R6"); idle(2, "R6");
        done = 1; tmode = 2'b00; step("R6"); idle(3, "R6");

        // R7: forced exception, trace held
        done = 1; forced = 1; tmode = 2'b10; step("R7"); idle(2, "R7");
        done = 1; tmode = 2'b00; step("R7"); idle(3, "R7");

        // R8: illegal
        done = 1; illegal = 1; tmode = 2'b10; step("R8"); idle(3, "R8");
        done = 1; illegal = 1; tmode = 2'b01; flow = 1; step("R8"); idle(3, "R8");

        // R3: long events and coincidence
        mmu = 1; step("R3"); idle(4, "R3");
        exc = 1; step("R3"); idle(4, "R3");
        exc = 1; done = 1; tmode = 2'b10; step("R3"); idle(5, "R3");

        // R9: back-to-back requests, queue and overflow
        for (int i = 0; i < 3; i++) begin done = 1; irq = (i == 1); step("R9"); end
        idle(10, "R9");
        for (int i = 0; i < 8; i++) begin mmu = 1; step("R9"); end
        idle(25, "R9");

        // random mix
        for (int i = 0; i < 1500; i++) begin
            int r;
            r = $urandom_range(99);
            done    = (r < 35);
            fault   = (r >= 35 && r < 40);
            forced  = done && ($urandom_range(99) < 15);
            illegal = ($urandom_range(99) < 10);
            irq     = ($urandom_range(99) < 20);
            flow    = ($urandom_range(99) < 40);
            tmode   = 2'($urandom_range(3));
            mmu     = ($urandom_range(99) < 4);
            exc     = ($urandom_range(99) < 3);
            step("R9");
        end
        idle(30, "R9");

        // R10 again: reset mid-activity
        done = 1; tmode = 2'b10; step("R10");
        do_reset();
        idle(3, "R10");

        // R4: halt holds line high despite other activity
        halt = 1; step("R4");
        for (int i = 0; i < 20; i++) begin done = (i % 3 == 0); step("R4"); end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule